// File: doc/BRIEF.md
# Receive idle-line interrupt generator

This block sits on the receive side of a UART, next to the character deserializer, and watches the serial input for an idle line. It keeps an idle status bit that follows the line. The status sets once the line has stayed high for one whole frame time. It clears when the deserializer reports a start bit. The frame time is 10 or 11 bit periods, chosen by a frame-length input, and each bit period is a fixed number of baud clock-enable pulses.

The block also raises an interrupt request for an idle line. The request sets when the line is idle, idle interrupts are enabled and an internal arming latch is set. The interrupt controller clears the request with an acknowledge strobe. Each time the request sets, it clears the arming latch. Only the character-received strobe from the deserializer sets the latch again. This gives one interrupt per idle period, however long the period lasts, while the status bit keeps tracking the line.

All inputs are plain control levels or single-cycle strobes. No data stream passes through the block, so no valid/ready handshake is needed.

Top module: `rxidle_irq_gen`

## Requirements
- R1: The idle status rises on the clock edge that takes the count of consecutive baud pulses with the line high to FRAME_BITS × SAMPLES_PER_BIT. FRAME_BITS is 10 when `long_frame_i` is 0 and 11 when it is 1. One pulse fewer leaves the status low.
- R2: In any cycle where `rxd_i` is 0, the count of high-line baud pulses restarts from zero. An idle status that is already set stays set.
- R3: A `start_det_i` strobe clears the idle status and the count on the next edge.
- R4: Cycles without `baud_tick_i` do not advance the count. While both `baud_tick_i` and `start_det_i` are low, the idle status does not change.
- R5: When the idle status is 1, `idle_irq_en_i` is 1 and the block is armed, `irq_o` rises on the following edge.
- R6: Once set, `irq_o` stays high until an `irq_ack_i` strobe. The strobe clears it on the next edge.
- R7: After the request has been raised once, no further request is raised for the same idle period, however long it lasts.
- R8: Only a `char_done_i` strobe re-arms the block. A start bit without a completed character does not re-arm it.
- R9: While `idle_irq_en_i` is 0, no request is raised and the armed state is kept. Setting the enable during an idle period then raises the request.
- R10: Reset clears the idle status and the request, and leaves the block armed.
- R11: A pending request is not cleared when the idle status falls. Only the acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, hardware or software |
| rxd_i | input | 1 | Synchronised receive line, 1 = mark |
| baud_tick_i | input | 1 | Baud sample enable, SAMPLES_PER_BIT pulses per bit |
| long_frame_i | input | 1 | 0: 10-bit frame, 1: 11-bit frame |
| start_det_i | input | 1 | Strobe: start bit detected |
| char_done_i | input | 1 | Strobe: complete character received |
| idle_irq_en_i | input | 1 | Idle interrupt enable |
| irq_ack_i | input | 1 | Strobe: interrupt acknowledge |
| idle_o | output | 1 | Idle line status |
| irq_o | output | 1 | Idle interrupt request |

## Verification
The bench builds the block with SAMPLES_PER_BIT = 2. That shortens the two frame times to 20 and 22 baud pulses, so the one-pulse-short boundary for both frame lengths can be reached in a few dozen cycles. It also allows long idle stretches, two and three frames deep, to show that no second request appears. The remaining parameters stay at their defaults, and the 10- and 11-bit frame choice is exercised through `long_frame_i`.

// File: rtl/rxidle_pkg.sv
package rxidle_pkg;

  // Number of baud pulses that make up one frame of idle line.
  function automatic int unsigned frame_pulses(input int unsigned bits,
                                               input int unsigned per_bit);
    return bits * per_bit;
  endfunction

endpackage

// File: rtl/rxidle_line_timer.sv
module rxidle_line_timer #(
  parameter int unsigned SAMPLES_PER_BIT = 16,
  parameter int unsigned SHORT_BITS      = 10,
  parameter int unsigned LONG_BITS       = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic baud_tick_i,
  input  logic long_frame_i,
  input  logic start_det_i,
  output logic idle_o
);
  import rxidle_pkg::*;

  localparam int unsigned SHORT_T = frame_pulses(SHORT_BITS, SAMPLES_PER_BIT);
  localparam int unsigned LONG_T  = frame_pulses(LONG_BITS, SAMPLES_PER_BIT);
  localparam int unsigned MAX_T   = (LONG_T > SHORT_T) ? LONG_T : SHORT_T;
  localparam int unsigned CW      = $clog2(MAX_T + 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] limit;
  logic          idle_q;

  assign limit = long_frame_i ? CW'(LONG_T) : CW'(SHORT_T);

  // Saturating count of high-line baud pulses; a start bit wins over all.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      idle_q <= 1'b0;
    end else if (start_det_i) begin
      run_q  <= '0;
      idle_q <= 1'b0;
    end else if (!rxd_i) begin
      run_q  <= '0;
    end else if (baud_tick_i) begin
      if (run_q < limit) run_q <= run_q + CW'(1);
      if (run_q >= limit - CW'(1)) idle_q <= 1'b1;
    end
  end

  assign idle_o = idle_q;

  // R3: a start bit drops the status on the next edge
  p_start_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i |=> !idle_o);

  // R4: without a baud pulse or a start bit the status holds
  p_no_tick_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!baud_tick_i && !start_det_i) |=> $stable(idle_o));

  // R2: a low line can never bring the status up
  p_low_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !rxd_i) |=> !idle_o);

endmodule

// File: rtl/rxidle_irq_latch.sv
module rxidle_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic en_i,
  input  logic char_done_i,
  input  logic ack_i,
  output logic req_o
);

  logic armed_q;
  logic req_q;
  logic fire;

  assign fire = idle_i & en_i & armed_q;

  // Request: set by fire, cleared only by acknowledge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (fire)   req_q <= 1'b1;
    else if (ack_i)  req_q <= 1'b0;
  end

  // Arming: a finished character re-arms, firing disarms.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b1;
    else if (char_done_i) armed_q <= 1'b1;
    else if (fire)        armed_q <= 1'b0;
  end

  assign req_o = req_q;

  // R6: the request holds until acknowledged
  p_hold_until_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q);

  // R6: acknowledge clears when no new fire can occur
  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !armed_q) |=> !req_q);

  // R9: a rising request needs idle and enable in the cycle before
  p_rise_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(idle_i && en_i));

  // R7: a rising request consumes the arming
  p_once_per_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !char_done_i && !$past(char_done_i)) |-> !armed_q || !$rose(req_q));

  // R8: arming only comes back through a finished character
  p_rearm_by_char_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(char_done_i));

endmodule

// File: rtl/rxidle_irq_gen.sv
module rxidle_irq_gen #(
  parameter int unsigned SAMPLES_PER_BIT = 16,
  parameter int unsigned SHORT_BITS      = 10,
  parameter int unsigned LONG_BITS       = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic baud_tick_i,
  input  logic long_frame_i,
  input  logic start_det_i,
  input  logic char_done_i,
  input  logic idle_irq_en_i,
  input  logic irq_ack_i,
  output logic idle_o,
  output logic irq_o
);

  logic idle_w;

  rxidle_line_timer #(
    .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
    .SHORT_BITS      (SHORT_BITS),
    .LONG_BITS       (LONG_BITS)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rxd_i        (rxd_i),
    .baud_tick_i  (baud_tick_i),
    .long_frame_i (long_frame_i),
    .start_det_i  (start_det_i),
    .idle_o       (idle_w)
  );

  rxidle_irq_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (idle_w),
    .en_i        (idle_irq_en_i),
    .char_done_i (char_done_i),
    .ack_i       (irq_ack_i),
    .req_o       (irq_o)
  );

  assign idle_o = idle_w;

  // R5: a rising request follows an idle status already present
  p_irq_after_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(idle_o));

  // R11: the status falling does not take a pending request with it
  p_fall_keeps_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

endmodule

// File: tb/rxidle_irq_gen_bench.sv
`timescale 1ns/1ps
module rxidle_irq_gen_bench;

  localparam int unsigned SPB   = 2;
  localparam int unsigned NVEC  = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0, lng = 1'b0, st = 1'b0, ch = 1'b0, en = 1'b1, ack = 1'b0;
  logic idle, irq;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rxidle_irq_gen #(.SAMPLES_PER_BIT(SPB)) u_rxidle_irq_gen (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .baud_tick_i(tick),
    .long_frame_i(lng), .start_det_i(st), .char_done_i(ch),
    .idle_irq_en_i(en), .irq_ack_i(ack), .idle_o(idle), .irq_o(irq)
  );

  // Vector: [19:16] requirement number, [15] rxd, [14] enable, [13] long frame,
  // [12] start strobe, [11] char strobe, [10] ack strobe, [9:2] baud pulses,
  // [1] expected idle, [0] expected request. Frame = 20 pulses short, 22 long.
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd1,  6'b110000, 8'd19, 2'b00},  // R1 one pulse short
    {4'd1,  6'b110000, 8'd1,  2'b11},  // R1 R5 boundary reached
    {4'd6,  6'b110000, 8'd40, 2'b11},  // R6 held without ack
    {4'd6,  6'b110001, 8'd0,  2'b10},  // R6 ack clears
    {4'd7,  6'b110000, 8'd60, 2'b10},  // R7 long idle, no second request
    {4'd3,  6'b010100, 8'd5,  2'b00},  // R3 start bit
    {4'd8,  6'b110010, 8'd0,  2'b00},  // R8 char re-arms
    {4'd5,  6'b110000, 8'd20, 2'b11},  // R5 new idle period
    {4'd11, 6'b010100, 8'd2,  2'b01},  // R11 start keeps request
    {4'd6,  6'b010001, 8'd0,  2'b00},  // R6 ack
    {4'd3,  6'b010100, 8'd3,  2'b00},  // R3 start, no char
    {4'd8,  6'b110000, 8'd30, 2'b10},  // R8 not re-armed
    {4'd3,  6'b010100, 8'd2,  2'b00},  // R3
    {4'd9,  6'b100010, 8'd25, 2'b10},  // R9 enable low
    {4'd9,  6'b110000, 8'd0,  2'b11},  // R9 enable rises
    {4'd6,  6'b110001, 8'd0,  2'b10},  // R6 ack
    {4'd3,  6'b010100, 8'd1,  2'b00},  // R3
    {4'd1,  6'b111010, 8'd21, 2'b00},  // R1 long frame one short
    {4'd1,  6'b111000, 8'd1,  2'b11},  // R1 long frame reached
    {4'd6,  6'b111001, 8'd0,  2'b10},  // R6 ack
    {4'd3,  6'b010100, 8'd1,  2'b00},  // R3
    {4'd2,  6'b110010, 8'd15, 2'b00},  // R2 partial run
    {4'd2,  6'b010000, 8'd1,  2'b00},  // R2 low line, no start
    {4'd2,  6'b110000, 8'd19, 2'b00},  // R2 count restarted
    {4'd2,  6'b110000, 8'd1,  2'b11},  // R2 full frame after restart
    {4'd6,  6'b110001, 8'd0,  2'b10}   // R6 ack
  };

  task automatic chk(input int req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // One strobe cycle, then the baud pulses, then one settling cycle.
  task automatic run_step(input logic [19:0] v);
    @(negedge clk);
    rxd = v[15]; en = v[14]; lng = v[13]; st = v[12]; ch = v[11]; ack = v[10]; tick = 1'b0;
    @(negedge clk);
    st = 1'b0; ch = 1'b0; ack = 1'b0;
    for (int i = 0; i < int'(v[9:2]); i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(10, idle, 1'b0, "idle in reset");             // R10
    chk(10, irq,  1'b0, "irq in reset");
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(4, idle, 1'b0, "no baud pulses, line high");  // R4

    for (int k = 0; k < NVEC; k++) begin
      run_step(VEC[k]);
      chk(int'(VEC[k][19:16]), idle, VEC[k][1], $sformatf("step %0d idle", k));
      chk(int'(VEC[k][19:16]), irq,  VEC[k][0], $sformatf("step %0d irq", k));
    end

    // R10: reset while a request is pending, then armed again afterwards
    run_step({4'd10, 6'b010100, 8'd1, 2'b00});
    run_step({4'd10, 6'b110010, 8'd20, 2'b00});
    chk(10, irq, 1'b1, "request before reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(10, idle, 1'b0, "idle cleared by reset");
    chk(10, irq,  1'b0, "irq cleared by reset");
    rst_n = 1'b1;
    run_step({4'd10, 6'b110000, 8'd20, 2'b00});
    chk(10, idle, 1'b1, "idle after reset");
    chk(10, irq,  1'b1, "armed after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule